// File: doc/BRIEF.md
# Vector Scalar Move Unit

This unit copies one element between a vector register and a scalar register. In the vector-to-scalar direction it takes element 0 of a source vector register and produces a result as wide as a scalar register. In the scalar-to-vector direction it writes a scalar value into element 0 of a destination vector register. Every element above element 0 keeps its previous value. Integer and floating-point variants share the datapath. They differ only in which scalar register file gets the write enable.

The element width (SEW) can be 8, 16, 32 or 64 bits. A mode input selects a scalar width (XLEN) of 64 or 32 bits. When SEW is narrower than XLEN, the moved element is sign-extended. When SEW is wider, the element is truncated. Only a single vector register is touched. The register grouping factor, the vector length and the start index do not change the result, so the move still happens when the vector length is zero.

A request is accepted in one cycle, and the result is registered and presented one cycle later. The old destination contents arrive on an input so that the tail can be carried through unchanged.

Top module: `vsmove_unit`

## Requirements
- R1: A result appears with `out_valid` high exactly one cycle after a cycle with `req_valid` high. Without a request, `out_valid` and all three write enables are low.
- R2: `op[0]` selects the direction: 0 is vector-to-scalar and 1 is scalar-to-vector. `op[1]` selects floating point. Op 00 raises only `x_we`, op 10 raises only `f_we`, and ops 01 and 11 raise only `v_we`.
- R3: The SEW code maps as follows: `sew`=0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. A vector-to-scalar move takes bits [SEW-1:0] of `vs2` as the element.
- R4: When SEW is less than XLEN, the vector-to-scalar result is the element sign-extended to XLEN bits.
- R5: When SEW is greater than XLEN (SEW 64 with a 32-bit XLEN), only the low XLEN bits of the element are moved.
- R6: With `xlen32`=1, XLEN is 32 and bits [63:32] of `scalar_out` are zero. With `xlen32`=0, XLEN is 64.
- R7: A scalar-to-vector move writes the low SEW bits of the scalar into bits [SEW-1:0] of `vd_out`. With a 32-bit XLEN, the scalar is first sign-extended from bit 31.
- R8: In a scalar-to-vector move, bits [VLEN-1:SEW] of `vd_out` equal those of `vd_old`.
- R9: `vl`, `vstart` and `lmul` have no effect on any output. This includes `vl`=0 and `vstart` >= `vl`.
- R10: The floating-point ops produce the same data as the integer ops of the same direction.
- R11: After reset, `out_valid`, the write enables, `scalar_out` and `vd_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| op | input | 2 | Bit 0 is the direction, bit 1 is floating point |
| sew | input | 2 | Element width code |
| xlen32 | input | 1 | 1 selects a 32-bit scalar width |
| lmul | input | 3 | Register grouping factor (ignored) |
| vl | input | VL_W | Vector length (ignored) |
| vstart | input | VL_W | Start index (ignored) |
| vs2 | input | VLEN | Source vector register |
| vd_old | input | VLEN | Prior destination vector contents |
| scalar_in | input | 64 | Scalar source operand |
| out_valid | output | 1 | Result valid |
| x_we | output | 1 | Integer scalar write enable |
| f_we | output | 1 | Floating-point scalar write enable |
| v_we | output | 1 | Vector write enable |
| scalar_out | output | 64 | Scalar result |
| vd_out | output | VLEN | New destination vector contents |

## Verification
The bench builds the unit with VLEN = 128. This keeps the 64-bit tail above the widest element visible while keeping the vectors short. It sweeps every op, every SEW code and both XLEN modes over data patterns with the sign bit of each element width both set and clear. This reaches every extend and truncate case. A second sweep repeats moves with `vl` = 0, `vstart` above `vl` and several `lmul` values, and expects identical data.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  localparam int unsigned XW = 64;

  typedef enum logic [1:0] {
    SEW_8  = 2'd0,
    SEW_16 = 2'd1,
    SEW_32 = 2'd2,
    SEW_64 = 2'd3
  } sew_e;

  typedef enum logic [1:0] {
    OP_V2X = 2'b00,
    OP_X2V = 2'b01,
    OP_V2F = 2'b10,
    OP_F2V = 2'b11
  } op_e;

  function automatic logic [XW-1:0] elem_mask(input sew_e s);
    case (s)
      SEW_8:   elem_mask = 64'h0000_0000_0000_00FF;
      SEW_16:  elem_mask = 64'h0000_0000_0000_FFFF;
      SEW_32:  elem_mask = 64'h0000_0000_FFFF_FFFF;
      default: elem_mask = '1;
    endcase
  endfunction

  function automatic logic [XW-1:0] sext_elem(input logic [XW-1:0] x, input sew_e s);
    case (s)
      SEW_8:   sext_elem = {{56{x[7]}}, x[7:0]};
      SEW_16:  sext_elem = {{48{x[15]}}, x[15:0]};
      SEW_32:  sext_elem = {{32{x[31]}}, x[31:0]};
      default: sext_elem = x;
    endcase
  endfunction
endpackage

// File: rtl/vsm_extract.sv
module vsm_extract
  import vsm_pkg::*;
(
  input  logic [XW-1:0] vs2_lo,
  input  sew_e          sew,
  input  logic          xlen32,
  output logic [XW-1:0] res
);
  logic [XW-1:0] full;

  always_comb begin
    full = sext_elem(vs2_lo, sew);
    res  = xlen32 ? {32'b0, full[31:0]} : full;
  end
endmodule

// File: rtl/vsm_insert.sv
module vsm_insert
  import vsm_pkg::*;
#(
  parameter int unsigned VLEN = 1024
) (
  input  logic [VLEN-1:0] vd_old,
  input  logic [XW-1:0]   scalar,
  input  sew_e            sew,
  input  logic            xlen32,
  output logic [VLEN-1:0] vd_new
);
  localparam int unsigned TAIL_W = VLEN - XW;

  logic [XW-1:0] s_ext;
  logic [XW-1:0] m;
  logic [XW-1:0] low;

  always_comb begin
    s_ext = xlen32 ? {{32{scalar[31]}}, scalar[31:0]} : scalar;
    m     = elem_mask(sew);
    low   = (vd_old[XW-1:0] & ~m) | (s_ext & m);
  end

  generate
    if (TAIL_W > 0) begin : g_tail
      assign vd_new = {vd_old[VLEN-1:XW], low};
    end else begin : g_notail
      assign vd_new = low;
    end
  endgenerate
endmodule

// File: rtl/vsmove_unit.sv
module vsmove_unit
  import vsm_pkg::*;
#(
  parameter int unsigned VLEN = 1024,
  localparam int unsigned VL_W = $clog2(VLEN) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      op,
  input  logic [1:0]      sew,
  input  logic            xlen32,
  input  logic [2:0]      lmul,
  input  logic [VL_W-1:0] vl,
  input  logic [VL_W-1:0] vstart,
  input  logic [VLEN-1:0] vs2,
  input  logic [VLEN-1:0] vd_old,
  input  logic [63:0]     scalar_in,
  output logic            out_valid,
  output logic            x_we,
  output logic            f_we,
  output logic            v_we,
  output logic [63:0]     scalar_out,
  output logic [VLEN-1:0] vd_out
);
  sew_e          sew_q;
  logic          dir_x2v;
  logic          is_fp;
  logic [XW-1:0] ext_res;
  logic [VLEN-1:0] ins_res;

  assign sew_q   = sew_e'(sew);
  assign dir_x2v = op[0];
  assign is_fp   = op[1];

  vsm_extract u_extract (
    .vs2_lo (vs2[XW-1:0]),
    .sew    (sew_q),
    .xlen32 (xlen32),
    .res    (ext_res)
  );

  vsm_insert #(.VLEN(VLEN)) u_insert (
    .vd_old (vd_old),
    .scalar (scalar_in),
    .sew    (sew_q),
    .xlen32 (xlen32),
    .vd_new (ins_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      x_we       <= 1'b0;
      f_we       <= 1'b0;
      v_we       <= 1'b0;
      scalar_out <= '0;
      vd_out     <= '0;
    end else begin
      out_valid <= req_valid;
      x_we      <= req_valid && !dir_x2v && !is_fp;
      f_we      <= req_valid && !dir_x2v && is_fp;
      v_we      <= req_valid && dir_x2v;
      if (req_valid) begin
        scalar_out <= dir_x2v ? '0 : ext_res;
        vd_out     <= dir_x2v ? ins_res : vd_old;
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(x_we || f_we || v_we)); // R1
  AST_ONE_WE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({x_we, f_we, v_we}) == 1); // R2
  AST_SEXT8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !v_we && $past(sew) == 2'd0 && !$past(xlen32))
      |-> (scalar_out[63:8] == {56{scalar_out[7]}})); // R4
  AST_X32_UPPER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !v_we && $past(xlen32)) |-> scalar_out[63:32] == 32'b0); // R6
  AST_TAIL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && v_we) |-> vd_out[VLEN-1:XW] == $past(vd_old[VLEN-1:XW])); // R8
  AST_INPUTS_KNOWN: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !$isunknown({op, sew, xlen32, lmul, vl, vstart, vs2, vd_old, scalar_in})); // R9
endmodule

// File: tb/vsmove_unit_tb.sv
`timescale 1ns/1ps
module vsmove_unit_tb;
  localparam int unsigned VLEN = 128;
  localparam int unsigned VL_W = $clog2(VLEN) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] op = '0;
  logic [1:0] sew = '0;
  logic xlen32 = 1'b0;
  logic [2:0] lmul = '0;
  logic [VL_W-1:0] vl = '0;
  logic [VL_W-1:0] vstart = '0;
  logic [VLEN-1:0] vs2 = '0;
  logic [VLEN-1:0] vd_old = '0;
  logic [63:0] scalar_in = '0;
  logic out_valid, x_we, f_we, v_we;
  logic [63:0] scalar_out;
  logic [VLEN-1:0] vd_out;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vsmove_unit #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .op(op), .sew(sew),
    .xlen32(xlen32), .lmul(lmul), .vl(vl), .vstart(vstart), .vs2(vs2),
    .vd_old(vd_old), .scalar_in(scalar_in), .out_valid(out_valid),
    .x_we(x_we), .f_we(f_we), .v_we(v_we), .scalar_out(scalar_out),
    .vd_out(vd_out)
  );

  function automatic logic [63:0] msk(int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] sx(logic [63:0] x, int w);
    if (w == 64) return x;
    return x[w-1] ? (x | ~msk(w)) : (x & msk(w));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic move(input logic [1:0] o, input int sc, input bit x32,
                      input logic [63:0] vlo, input logic [63:0] sval,
                      input logic [VLEN-1:0] old, input int vlv, input int vst,
                      input int lm, input string tag);
    int w, xl;
    logic [63:0] e, exp_s, se;
    logic [VLEN-1:0] exp_v;
    logic [2:0] exp_we;
    w  = 8 << sc;
    xl = x32 ? 32 : 64;
    @(negedge clk);
    req_valid = 1'b1; op = o; sew = sc[1:0]; xlen32 = x32;
    vs2 = {~vlo, vlo}; scalar_in = sval; vd_old = old;
    vl = VL_W'(vlv); vstart = VL_W'(vst); lmul = lm[2:0];
    @(negedge clk);
    req_valid = 1'b0;
    exp_we = (o[0]) ? 3'b001 : (o[1] ? 3'b010 : 3'b100);
    chk(out_valid == 1'b1, {tag, " R1 valid"}, VLEN'(out_valid), 1);
    chk({x_we, f_we, v_we} == exp_we, {tag, " R2 we"}, VLEN'({x_we, f_we, v_we}), VLEN'(exp_we));
    if (!o[0]) begin
      e = vlo & msk(w);
      exp_s = (w >= xl) ? (e & msk(xl)) : (sx(e, w) & msk(xl));
      chk(scalar_out == exp_s, {tag, (w < xl) ? " R4 R3" : (w > xl ? " R5 R6" : " R3")},
          VLEN'(scalar_out), VLEN'(exp_s));
    end else begin
      se = sx(sval, xl);
      exp_v = old;
      exp_v[63:0] = (old[63:0] & ~msk(w)) | (se & msk(w));
      chk(vd_out == exp_v, {tag, " R7 R8"}, vd_out, exp_v);
    end
    @(negedge clk);
    chk(!out_valid && !x_we && !f_we && !v_we, {tag, " R1 idle"},
        VLEN'({out_valid, x_we, f_we, v_we}), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [63:0] pats [6];
    logic [63:0] d1, d2, ref_s;
    logic [VLEN-1:0] ref_v;
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'hFEDC_BA98_7654_3210;
    pats[2] = 64'h8000_0000_8000_8080;
    pats[3] = 64'h7FFF_FFFF_7FFF_7F7F;
    pats[4] = 64'h0000_0000_0000_0000;
    pats[5] = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(!out_valid && !x_we && !f_we && !v_we && scalar_out == 0 && vd_out == 0,
        "R11 reset", vd_out, 0);
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 4; s++)
        for (int x = 0; x < 2; x++)
          for (int p = 0; p < 6; p++)
            move(o[1:0], s, x[0], pats[p], pats[5-p],
                 {pats[(p+1)%6], pats[(p+2)%6]}, 16, 0, 0,
                 o[1] ? "R10 sweep" : "sweep");
    // R9: vl, vstart, lmul have no effect
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 4; s++) begin
        move(o[1:0], s, 1'b0, pats[2], pats[1], {pats[0], pats[3]}, 0, 0, 0, "R9 vl0");
        ref_s = scalar_out; ref_v = vd_out;
        move(o[1:0], s, 1'b0, pats[2], pats[1], {pats[0], pats[3]}, 3, 9, 3, "R9 vstart>vl");
        chk(scalar_out == ref_s && vd_out == ref_v, "R9 same", vd_out, ref_v);
        move(o[1:0], s, 1'b0, pats[2], pats[1], {pats[0], pats[3]}, 128, 0, 5, "R9 lmul");
      end
    // R10: fp and int give identical data
    move(2'b00, 1, 1'b0, pats[2], 0, 0, 4, 0, 0, "R10 int");
    d1 = scalar_out;
    move(2'b10, 1, 1'b0, pats[2], 0, 0, 4, 0, 0, "R10 fp");
    d2 = scalar_out;
    chk(d1 == d2, "R10 match", VLEN'(d2), VLEN'(d1));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule